// File: doc/BRIEF.md
# Crate Command Register Interface

This block sits between an 8-bit microprocessor bus and the dataway sequencer of a single-crate controller. It watches two address spaces. The first is a 512-byte memory window that can only be written. One store into this window carries a whole dataway command. The low nine address bits give the station and the subaddress. The data byte gives the function code and two control bits for arbitration and release. The second is a block of eight I/O ports. Three of them reach the 24-bit write and read data registers, one byte each. One holds a status byte. The upper four are passed on to an interrupt controller.

After a command is accepted, the block holds it in a buffer and offers it to the sequencer on a valid/ready interface. `cmd_valid` stays high, with all fields stable, until the sequencer raises `cmd_ready`. The block never withdraws an offered command. The sequencer reports the end of the cycle with a single-cycle `done_valid` pulse. This completion path has no ready signal, because the block can always take it. From acceptance until that pulse, the block is busy. While it is busy, any CPU access to the window or to the four data ports asserts WAIT and has no effect. The CPU keeps the access on the bus, and the block performs it in the first cycle after the cycle has completed.

Top module: `crate_cmd_port`

## Requirements
- R1: A memory write is taken as a command only when address bits [15:9] equal those of the window base (default 0x3000, so 0x3000 to 0x31FF). Writes outside the window start nothing.
- R2: An accepted window write buffers the following fields. Station = address[8:4]. Subaddress = address[3:0]. Function = data[4:0]. Lockout-mode bit = data[5]. Hold-dataway bit = data[6]. Data bit 7 is ignored.
- R3: `cmd_valid` rises on the clock edge that accepts the window write. It then stays high, with every command field stable, until the edge on which `cmd_ready` is sampled high.
- R4: I/O writes to ports base+0, base+1 and base+2 (default base 8) load the low, middle and high byte of the 24-bit write register. That register drives `cmd_wdata`.
- R5: On `done_valid`, if the buffered function is in the read class, all 24 `done_rdata` bits are latched into the read register. I/O reads of base+0/+1/+2 return its low, middle and high byte, in any order or subset. For other functions the read register keeps its value.
- R6: On every `done_valid` the status byte is loaded with bit0 = Q, bit1 = X, bit2 = I, bit3 = LAM demand and bits 7:4 = 0. An I/O read of base+3 returns it. It is zero after reset.
- R7: An I/O write to base+3 loads the full status byte, and it reads back unchanged.
- R8: From command acceptance until the edge that samples `done_valid`, a window write or an I/O access to base+0..+3 asserts `cpu_wait` in the same cycle. Such an access changes no register.
- R9: An I/O access to base+4..+7 raises `irq_sel` with `irq_reg` = port offset minus 4. `cpu_rdata` is 0 for these reads, and they are never held by WAIT.
- R10: Functions 0 to 7 are read class (`cmd_is_read`). Functions 16 to 23 are write class (`cmd_is_write`). All other codes are dataless, with neither flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address; the low byte is used for I/O |
| cpu_wdata | input | 8 | CPU write data |
| cpu_mem_wr | input | 1 | Memory write strobe |
| cpu_io_wr | input | 1 | I/O write strobe |
| cpu_io_rd | input | 1 | I/O read strobe |
| cpu_rdata | output | 8 | I/O read data |
| cpu_wait | output | 1 | WAIT request to the CPU |
| irq_sel | output | 1 | Access to the interrupt controller ports |
| irq_reg | output | 2 | Interrupt controller register index |
| cmd_valid | output | 1 | Command offered to the sequencer |
| cmd_ready | input | 1 | Sequencer takes the command |
| cmd_station | output | 5 | Station number |
| cmd_sub | output | 4 | Subaddress |
| cmd_func | output | 5 | Function code |
| cmd_lockout | output | 1 | Use lockout arbitration |
| cmd_hold | output | 1 | Keep the dataway after this cycle |
| cmd_is_read | output | 1 | Function is read class |
| cmd_is_write | output | 1 | Function is write class |
| cmd_wdata | output | 24 | Write data for the dataway |
| done_valid | input | 1 | Dataway cycle completed |
| done_rdata | input | 24 | Dataway read bits |
| done_q | input | 1 | Q response |
| done_x | input | 1 | X response |
| done_i | input | 1 | Inhibit line |
| done_lam | input | 1 | LAM demand of the addressed station |

## Verification
Some properties are checked on every cycle:
- An offered command stays steady until `cmd_ready`.
- `cmd_valid` only rises after a window write.
- A completion only arrives while the block is busy.
- A status byte loaded by a completion has its upper nibble clear.
- A write held by WAIT leaves the write data untouched.

Other behaviour can only be shown by the bench scenarios:
- The exact decode of station and subaddress at the window edges.
- Class-dependent latching of the read register.
- Deferral of an I/O write until the cycle ends.
- Read-back of a status byte written by the CPU.

// File: rtl/crate_if_pkg.sv
package crate_if_pkg;

  localparam int IO_SPAN  = 8;
  localparam int OFF_W    = $clog2(IO_SPAN);
  localparam int STA_W    = 5;
  localparam int SUB_W    = 4;
  localparam int FN_W     = 5;

  // status bit positions
  localparam int ST_Q   = 0;
  localparam int ST_X   = 1;
  localparam int ST_I   = 2;
  localparam int ST_LAM = 3;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_READ  = 2'd1,
    FC_WRITE = 2'd2
  } fclass_e;

  typedef struct packed {
    logic             hold;
    logic             lockout;
    logic [FN_W-1:0]  func;
    logic [SUB_W-1:0] sub;
    logic [STA_W-1:0] station;
  } cmd_t;

  function automatic fclass_e classify(input logic [FN_W-1:0] f);
    fclass_e c;
    case (f[FN_W-1:FN_W-2])
      2'b00:   c = FC_READ;
      2'b10:   c = FC_WRITE;
      default: c = FC_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/crate_addr_decode.sv
module crate_addr_decode
  import crate_if_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              WIN_BITS = 9,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h3000,
  parameter int              IO_W     = 8,
  parameter logic [IO_W-1:0] IO_BASE  = 8'h08
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_wr,
  output logic              win_wr,
  output logic              data_hit,
  output logic              irq_hit,
  output logic [OFF_W-1:0]  io_off
);

  logic [IO_W-1:0] io_addr;
  logic [IO_W-1:0] io_delta;
  logic            in_block;
  logic            win_hit;

  assign win_hit  = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
  assign win_wr   = mem_wr && win_hit;

  assign io_addr  = addr[IO_W-1:0];
  assign io_delta = io_addr - IO_BASE;
  assign in_block = (io_addr >= IO_BASE) && (io_delta < IO_W'(IO_SPAN));
  assign io_off   = io_delta[OFF_W-1:0];

  // upper half of the port block belongs to the interrupt controller
  assign data_hit = in_block && !io_off[OFF_W-1];
  assign irq_hit  = in_block &&  io_off[OFF_W-1];

endmodule

// File: rtl/crate_cmd_buffer.sv
module crate_cmd_buffer
  import crate_if_pkg::*;
#(
  parameter int WIN_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                win_wr,
  input  logic [WIN_BITS-1:0] win_off,
  input  logic [7:0]          wdata,
  input  logic                cmd_ready,
  input  logic                done_valid,
  output logic                cmd_valid,
  output cmd_t                cmd,
  output logic                busy,
  output fclass_e             fclass
);

  logic accept;
  logic unused_wdata;

  assign accept       = win_wr && !busy;
  assign unused_wdata = wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd       <= '0;
    end else begin
      if (accept) begin
        busy        <= 1'b1;
        cmd_valid   <= 1'b1;
        cmd.station <= win_off[SUB_W +: STA_W];
        cmd.sub     <= win_off[SUB_W-1:0];
        cmd.func    <= wdata[FN_W-1:0];
        cmd.lockout <= wdata[FN_W];
        cmd.hold    <= wdata[FN_W+1];
      end else begin
        if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
        if (done_valid)             busy      <= 1'b0;
      end
    end
  end

  assign fclass = classify(cmd.func);

  // R3: offered command is held steady until taken
  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd)));

  // R3: an offer only follows a window write
  p_start_after_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(win_wr));

  // R8: completion only while a cycle is in flight
  p_done_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> busy);

  // R8: an outstanding offer implies the block is busy
  p_valid_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

endmodule

// File: rtl/crate_data_regs.sv
module crate_data_regs
  import crate_if_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              done_valid,
  input  logic              latch_read,
  input  logic [DATA_W-1:0] dw_rdata,
  input  logic              st_q,
  input  logic              st_x,
  input  logic              st_i,
  input  logic              st_lam,
  output logic [DATA_W-1:0] wreg,
  output logic [BYTE_W-1:0] rbyte
);

  localparam int NBYTES     = DATA_W / BYTE_W;
  localparam int STATUS_OFF = NBYTES;

  logic [DATA_W-1:0] rreg;
  logic [BYTE_W-1:0] status;
  logic [BYTE_W-1:0] lane [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        wreg[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && off == OFF_W'(g))
        wreg[g*BYTE_W +: BYTE_W] <= wbyte;
    end
    assign lane[g] = rreg[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rreg <= '0;
    else if (done_valid && latch_read)
      rreg <= dw_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
    end else if (done_valid) begin
      status         <= '0;
      status[ST_Q]   <= st_q;
      status[ST_X]   <= st_x;
      status[ST_I]   <= st_i;
      status[ST_LAM] <= st_lam;
    end else if (wr_en && off == OFF_W'(STATUS_OFF)) begin
      status <= wbyte;
    end
  end

  always_comb begin
    rbyte = '0;
    for (int i = 0; i < NBYTES; i++)
      if (off == OFF_W'(i)) rbyte = lane[i];
    if (off == OFF_W'(STATUS_OFF)) rbyte = status;
  end

  // R6: a completion leaves the upper status nibble clear
  p_status_high_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_valid) |-> (status[BYTE_W-1:4] == '0));

  // R5: read register unchanged by completions outside the read class
  p_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_valid && !latch_read) |-> $stable(rreg));

endmodule

// File: rtl/crate_cmd_port.sv
module crate_cmd_port
  import crate_if_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_BITS = 9,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h3000,
  parameter logic [7:0]        IO_BASE  = 8'h08,
  parameter int                DATA_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_mem_wr,
  input  logic              cpu_io_wr,
  input  logic              cpu_io_rd,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_wait,
  output logic              irq_sel,
  output logic [1:0]        irq_reg,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [4:0]        cmd_station,
  output logic [3:0]        cmd_sub,
  output logic [4:0]        cmd_func,
  output logic              cmd_lockout,
  output logic              cmd_hold,
  output logic              cmd_is_read,
  output logic              cmd_is_write,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              done_valid,
  input  logic [DATA_W-1:0] done_rdata,
  input  logic              done_q,
  input  logic              done_x,
  input  logic              done_i,
  input  logic              done_lam
);

  logic             win_wr;
  logic             data_hit;
  logic             irq_hit;
  logic [OFF_W-1:0] io_off;
  logic             busy;
  cmd_t             cmd;
  fclass_e          fclass;
  logic             data_access;
  logic [7:0]       rbyte;

  crate_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE),
    .IO_W(8), .IO_BASE(IO_BASE)
  ) u_decode (
    .addr(cpu_addr), .mem_wr(cpu_mem_wr), .win_wr(win_wr),
    .data_hit(data_hit), .irq_hit(irq_hit), .io_off(io_off)
  );

  crate_cmd_buffer #(.WIN_BITS(WIN_BITS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr),
    .win_off(cpu_addr[WIN_BITS-1:0]), .wdata(cpu_wdata),
    .cmd_ready(cmd_ready), .done_valid(done_valid),
    .cmd_valid(cmd_valid), .cmd(cmd), .busy(busy), .fclass(fclass)
  );

  crate_data_regs #(.DATA_W(DATA_W), .BYTE_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cpu_io_wr && data_hit && !busy), .off(io_off), .wbyte(cpu_wdata),
    .done_valid(done_valid), .latch_read(fclass == FC_READ),
    .dw_rdata(done_rdata), .st_q(done_q), .st_x(done_x),
    .st_i(done_i), .st_lam(done_lam),
    .wreg(cmd_wdata), .rbyte(rbyte)
  );

  assign data_access  = data_hit && (cpu_io_rd || cpu_io_wr);
  assign cpu_wait     = busy && (win_wr || data_access);
  assign cpu_rdata    = (cpu_io_rd && data_hit && !busy) ? rbyte : 8'h00;
  assign irq_sel      = irq_hit && (cpu_io_rd || cpu_io_wr);
  assign irq_reg      = io_off[1:0];

  assign cmd_station  = cmd.station;
  assign cmd_sub      = cmd.sub;
  assign cmd_func     = cmd.func;
  assign cmd_lockout  = cmd.lockout;
  assign cmd_hold     = cmd.hold;
  assign cmd_is_read  = (fclass == FC_READ);
  assign cmd_is_write = (fclass == FC_WRITE);

  // R8: a write held off by WAIT does not touch the write data
  p_wait_freezes_wdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wait && cpu_io_wr) |=> $stable(cmd_wdata));

  // R9: interrupt controller ports are never stalled
  p_irq_no_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sel |-> !cpu_wait);

endmodule

// File: tb/crate_cmd_port_test.sv
module crate_cmd_port_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_mem_wr = 1'b0, cpu_io_wr = 1'b0, cpu_io_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        cpu_wait, irq_sel;
  logic [1:0]  irq_reg;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [4:0]  cmd_station, cmd_func;
  logic [3:0]  cmd_sub;
  logic        cmd_lockout, cmd_hold, cmd_is_read, cmd_is_write;
  logic [23:0] cmd_wdata;
  logic        done_valid = 1'b0;
  logic [23:0] done_rdata = '0;
  logic        done_q = 1'b0, done_x = 1'b0, done_i = 1'b0, done_lam = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [4:0] station; logic [3:0] sub; logic [4:0] func;
    logic lockout; logic hold; logic rd; logic wr;
  } exp_cmd_t;
  typedef struct { logic [7:0] val; string tag; } exp_rd_t;

  exp_cmd_t cmd_q[$];
  exp_rd_t  rd_q[$];

  // values the sequencer model returns on the next completion
  logic [23:0] nxt_rdata;
  logic [3:0]  nxt_st;   // {lam,i,x,q}

  crate_cmd_port uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_mem_wr = 1'b1;
    #1;
    while (cpu_wait) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_mem_wr = 1'b0;
  endtask

  task automatic io_write(input logic [7:0] p, input logic [7:0] d, output bit saw_wait);
    saw_wait = 0;
    @(negedge clk);
    cpu_addr = {8'h00, p}; cpu_wdata = d; cpu_io_wr = 1'b1;
    #1;
    while (cpu_wait) begin saw_wait = 1; @(negedge clk); #1; end
    @(negedge clk);
    cpu_io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] p, input logic [7:0] exp, input string tag);
    exp_rd_t e;
    e.val = exp; e.tag = tag;
    rd_q.push_back(e);
    @(negedge clk);
    cpu_addr = {8'h00, p}; cpu_io_rd = 1'b1;
    #1;
    while (cpu_wait) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_io_rd = 1'b0;
  endtask

  task automatic push_cmd(input logic [4:0] n, input logic [3:0] a, input logic [4:0] f,
                          input logic lk, input logic hd, input logic r, input logic w);
    exp_cmd_t e;
    e.station = n; e.sub = a; e.func = f; e.lockout = lk; e.hold = hd; e.rd = r; e.wr = w;
    cmd_q.push_back(e);
  endtask

  // monitor: read scoreboard
  always @(negedge clk) begin
    #2;
    if (cpu_io_rd && !cpu_wait && rd_q.size() > 0) begin
      exp_rd_t e;
      e = rd_q.pop_front();
      check(cpu_rdata == e.val, e.tag, 32'(cpu_rdata), 32'(e.val));
    end
  end

  // sequencer model and command scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        exp_cmd_t e;
        @(negedge clk);
        cmd_ready = 1'b1;
        if (cmd_q.size() == 0) begin
          check(1'b0, "R1 unexpected command", 32'(cmd_func), 32'hx);
        end else begin
          e = cmd_q.pop_front();
          check(cmd_valid, "R3 valid held", 32'(cmd_valid), 1);
          check(cmd_station == e.station && cmd_sub == e.sub, "R2 station/sub",
                {cmd_station, cmd_sub}, {e.station, e.sub});
          check(cmd_func == e.func && cmd_lockout == e.lockout && cmd_hold == e.hold,
                "R2 func/ctl", {cmd_hold, cmd_lockout, cmd_func}, {e.hold, e.lockout, e.func});
          check(cmd_is_read == e.rd && cmd_is_write == e.wr, "R10 class",
                {cmd_is_read, cmd_is_write}, {e.rd, e.wr});
        end
        @(negedge clk);
        cmd_ready = 1'b0;
        #1;
        check(!cmd_valid, "R3 valid drops after ready", 32'(cmd_valid), 0);
        repeat (3) @(negedge clk);
        done_valid = 1'b1; done_rdata = nxt_rdata;
        {done_lam, done_i, done_x, done_q} = nxt_st;
        @(negedge clk);
        done_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit sw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(!cmd_valid && !cpu_wait, "R3 reset idle", {cmd_valid, cpu_wait}, 0);
    io_read(8'd8, 8'h00, "R5 reset read byte");
    io_read(8'd11, 8'h00, "R6 reset status");

    // R4: load write register bytewise
    io_write(8'd8, 8'h11, sw);
    io_write(8'd9, 8'h22, sw);
    io_write(8'd10, 8'h33, sw);
    check(cmd_wdata == 24'h332211, "R4 write register", cmd_wdata, 24'h332211);

    // R2/R5/R6: read command, station 5 sub 3 F=2
    nxt_rdata = 24'hA1B2C3; nxt_st = 4'b1011;
    push_cmd(5'd5, 4'd3, 5'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    mem_write(16'h3053, 8'h02);
    io_read(8'd8,  8'hC3, "R5 low byte");
    io_read(8'd10, 8'hA1, "R5 high byte");
    io_read(8'd9,  8'hB2, "R5 middle byte");
    io_read(8'd11, 8'h0B, "R6 status bits");

    // R1 window top edge, R8 wait, R10 dataless; bit7 ignored (R2)
    nxt_rdata = 24'h123456; nxt_st = 4'b0100;
    push_cmd(5'd31, 4'd15, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0);
    mem_write(16'h31FF, 8'h89);
    io_write(8'd8, 8'h55, sw);
    check(sw, "R8 wait on busy access", 32'(sw), 1);
    check(cmd_wdata == 24'h332255, "R8 deferred write lands", cmd_wdata, 24'h332255);
    io_read(8'd8,  8'hC3, "R10 dataless keeps read register");
    io_read(8'd11, 8'h04, "R6 status after dataless");

    // write class with lockout and hold
    nxt_rdata = 24'hFFFFFF; nxt_st = 4'b1101;
    push_cmd(5'd2, 4'd1, 5'd16, 1'b1, 1'b1, 1'b0, 1'b1);
    mem_write(16'h3021, 8'h70);
    io_read(8'd10, 8'hA1, "R5 write class keeps read register");
    io_read(8'd11, 8'h0D, "R6 status after write");

    // R1: writes outside the window
    mem_write(16'h3200, 8'h02);
    mem_write(16'h2FFF, 8'h02);
    repeat (3) begin
      @(negedge clk); #1;
      check(!cmd_valid, "R1 outside window", 32'(cmd_valid), 0);
    end

    // R7: status written by CPU
    io_write(8'd11, 8'hF5, sw);
    io_read(8'd11, 8'hF5, "R7 status readback");

    // R9: interrupt controller port
    @(negedge clk);
    cpu_addr = 16'd13; cpu_io_rd = 1'b1;
    #1;
    check(irq_sel && irq_reg == 2'd1, "R9 irq select", {irq_sel, irq_reg}, 3'b101);
    check(cpu_rdata == 8'h00 && !cpu_wait, "R9 irq read data", cpu_rdata, 0);
    @(negedge clk);
    cpu_io_rd = 1'b0;

    repeat (4) @(negedge clk);
    check(cmd_q.size() == 0 && rd_q.size() == 0, "R3 scoreboards drained",
          cmd_q.size() + rd_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule